// File: doc/BRIEF.md
# Two-Level Hardware Breakpoint Trigger

This block watches a processor's bus accesses and reports when a programmed breakpoint condition has completed. For each access it receives a strobe, the low address bits, the access size, and the 32-bit data bus. It also receives a reference data value and two match flags that come from comparators outside the block: one for the program counter and one for the address. A 32-bit trigger definition word holds two trigger levels. Each level combines a PC condition, an address condition and a data-value condition. Each level has its own rule for combining them: all three, or PC alone versus address-and-data.

If the second level has no condition enabled, the block works as a single-level trigger and completes whenever level 1 fires. Otherwise it runs a two-step sequence. A level-1 hit arms the unit. A later level-2 hit completes the trigger and disarms it. Every completion raises the `trig_done` status pulse. Depending on the response field, the completion may also pulse a halt request or a debug interrupt request.

Data comparison assumes a big-endian bus. The block chooses the operand lane from the access size and the low address bits. It then compares that lane, right-justified, with the low bits of the reference value.

Top module: `bp_trigger`

## Requirements
- R1: Reset clears the definition word and the armed flag. With all level fields zero, no access ever produces `trig_done`, `halt_req` or `dbg_irq`.
- R2: Definition word layout. Bits [12:0] hold the level-1 field and bits [28:16] hold the level-2 field. Bits [31:30] hold the response code. Bits 29 and 15:13 have no effect. Inside a level field: bit 0 is the combining mode, bit 1 enables PC, bit 2 inverts PC, bit 3 enables address, bit 4 inverts address, and bit 5 inverts data. Bits 12:6 enable the data cases in this order: long, upper word, lower word, then the byte lanes for address 00, 01, 10 and 11.
- R3: With mode 0, a level fires on PC AND address AND data. A disabled condition counts as true.
- R4: With mode 1, a level fires on (enabled PC condition) OR (address AND data). A disabled address or data condition counts as true inside the conjunction. The conjunction counts only if at least one of address or data is enabled.
- R5: Size 00 is a byte access. Address 00 compares data[31:24], 01 compares data[23:16], 10 compares data[15:8] and 11 compares data[7:0], each against reference[7:0].
- R6: Size 01 is a word access. It compares data[31:16] when address bit 1 is 0 and data[15:0] when it is 1, against reference[15:0]. Size 10 is a long access and compares all 32 bits. Size 11 never satisfies an enabled data condition.
- R7: An inverted PC or address condition is true when its flag is 0. An inverted data condition is true when the access case is enabled and the value differs. An access whose case is not enabled fails the data condition regardless of inversion.
- R8: A level with no PC, address or data enable never fires.
- R9: When level 2 has any enable, a level-1 hit sets `lvl1_armed`. While the unit is armed, only level 2 is evaluated, and a hit completes the trigger and clears `lvl1_armed`.
- R10: A definition write clears `lvl1_armed`, and no completion occurs in the write cycle.
- R11: On completion, response 01 also pulses `halt_req` and response 10 also pulses `dbg_irq`. Responses 00 and 11 raise neither.
- R12: Outputs are registered. A completing access in cycle N gives one-cycle pulses in cycle N+1, and only accesses with `acc_valid` high are evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the definition word |
| cfg_wdata | input | 32 | New definition word |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_addr_lo | input | 2 | Access address bits [1:0] |
| acc_size | input | 2 | 00 byte, 01 word, 10 long, 11 none |
| acc_data | input | 32 | Bus data, big-endian lanes |
| data_ref | input | 32 | Reference value for the data condition |
| pc_hit | input | 1 | PC comparator match flag |
| addr_hit | input | 1 | Address comparator match flag |
| trig_done | output | 1 | Trigger completed (trace status) |
| halt_req | output | 1 | Halt request pulse |
| dbg_irq | output | 1 | Debug interrupt request pulse |
| lvl1_armed | output | 1 | Level 1 has fired in two-level mode |

## Verification
Every result is due one clock edge after the stimulus that causes it. This applies to `trig_done`, `halt_req` and `dbg_irq` after an access, and to `lvl1_armed` after an access or a definition write. The bench drives each access on a falling edge and samples on the next falling edge, after exactly one rising edge. After a definition write it samples on the falling edge that follows the write edge. Two-level sequences are checked one access at a time, and the armed state is compared after each access.

// File: rtl/bp_trig_pkg.sv
package bp_trig_pkg;

    localparam int DATA_W    = 32;
    localparam int LVL_W     = 13;
    localparam int HALF_W    = 16;
    localparam int NUM_LVL   = 2;
    localparam int NUM_CASES = 7;

    typedef enum logic [1:0] {
        RSP_TRACE = 2'b00,
        RSP_HALT  = 2'b01,
        RSP_IRQ   = 2'b10,
        RSP_RSVD  = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_NONE = 2'b11
    } size_e;

    // one level field, MSB first: case enables, inversions, enables, mode
    typedef struct packed {
        logic [NUM_CASES-1:0] case_en; // [0] long, [1] word hi, [2] word lo, [3..6] byte lanes
        logic                 data_inv;
        logic                 addr_inv;
        logic                 addr_en;
        logic                 pc_inv;
        logic                 pc_en;
        logic                 mode_or;
    } lvl_cfg_t;

    typedef struct packed {
        rsp_e     rsp;
        lvl_cfg_t lvl2;
        lvl_cfg_t lvl1;
    } trig_cfg_t;

    function automatic trig_cfg_t unpack_cfg(input logic [DATA_W-1:0] w);
        trig_cfg_t c;
        c.rsp  = rsp_e'(w[DATA_W-1 -: 2]);
        c.lvl2 = lvl_cfg_t'(w[HALF_W +: LVL_W]);
        c.lvl1 = lvl_cfg_t'(w[0 +: LVL_W]);
        return c;
    endfunction

endpackage

// File: rtl/bp_data_sel.sv
module bp_data_sel
    import bp_trig_pkg::*;
(
    input  logic [1:0]           addr_lo,
    input  logic [1:0]           size,
    input  logic [DATA_W-1:0]    data,
    input  logic [DATA_W-1:0]    data_ref,
    output logic [NUM_CASES-1:0] case_oh,
    output logic                 value_eq
);
    logic [DATA_W-1:0] operand;
    logic [DATA_W-1:0] width_mask;

    always_comb begin
        case_oh    = '0;
        operand    = '0;
        width_mask = '0;
        unique case (size_e'(size))
            SZ_LONG: begin
                case_oh[0] = 1'b1;
                operand    = data;
                width_mask = '1;
            end
            SZ_WORD: begin
                case_oh    = addr_lo[1] ? NUM_CASES'(4) : NUM_CASES'(2);
                operand    = {16'h0, addr_lo[1] ? data[15:0] : data[31:16]};
                width_mask = 32'h0000_FFFF;
            end
            SZ_BYTE: begin
                case_oh    = NUM_CASES'(8) << addr_lo;
                operand    = {24'h0, data[8*(3-addr_lo) +: 8]};
                width_mask = 32'h0000_00FF;
            end
            default: begin
                case_oh = '0;
            end
        endcase
    end

    assign value_eq = (operand == (data_ref & width_mask));

endmodule

// File: rtl/bp_level_eval.sv
module bp_level_eval
    import bp_trig_pkg::*;
(
    input  lvl_cfg_t             cfg,
    input  logic                 valid,
    input  logic                 pc_hit,
    input  logic                 addr_hit,
    input  logic [NUM_CASES-1:0] case_oh,
    input  logic                 value_eq,
    output logic                 any_en,
    output logic                 fire
);
    logic data_en, pc_c, addr_c, data_c;
    logic pc_t, addr_t, data_t;
    logic and_form, or_form;

    assign data_en = |cfg.case_en;
    assign pc_c    = pc_hit ^ cfg.pc_inv;
    assign addr_c  = addr_hit ^ cfg.addr_inv;
    assign data_c  = (|(cfg.case_en & case_oh)) & (value_eq ^ cfg.data_inv);

    assign pc_t   = cfg.pc_en   ? pc_c   : 1'b1;
    assign addr_t = cfg.addr_en ? addr_c : 1'b1;
    assign data_t = data_en     ? data_c : 1'b1;

    assign any_en   = cfg.pc_en | cfg.addr_en | data_en;
    assign and_form = pc_t & addr_t & data_t;
    assign or_form  = (cfg.pc_en & pc_c) | ((cfg.addr_en | data_en) & addr_t & data_t);
    assign fire     = valid & any_en & (cfg.mode_or ? or_form : and_form);

    always_comb begin
        if (!any_en) assert_idle_level_R8: assert (!fire);
    end

endmodule

// File: rtl/bp_trigger.sv
module bp_trigger
    import bp_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_addr_lo,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_data,
    input  logic [31:0]       data_ref,
    input  logic              pc_hit,
    input  logic              addr_hit,
    output logic              trig_done,
    output logic              halt_req,
    output logic              dbg_irq,
    output logic              lvl1_armed
);
    trig_cfg_t cfg_q;
    logic      unused_cfg_bits;

    assign unused_cfg_bits = ^{cfg_wdata[29], cfg_wdata[15:13]};

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= unpack_cfg(cfg_wdata);
    end

    logic [NUM_CASES-1:0] case_oh;
    logic                 value_eq;

    bp_data_sel u_sel (
        .addr_lo  (acc_addr_lo),
        .size     (acc_size),
        .data     (acc_data),
        .data_ref (data_ref),
        .case_oh  (case_oh),
        .value_eq (value_eq)
    );

    lvl_cfg_t           lvl_cfg [NUM_LVL];
    logic [NUM_LVL-1:0] lvl_any;
    logic [NUM_LVL-1:0] lvl_fire;

    assign lvl_cfg[0] = cfg_q.lvl1;
    assign lvl_cfg[1] = cfg_q.lvl2;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
        bp_level_eval u_lvl (
            .cfg      (lvl_cfg[g]),
            .valid    (acc_valid),
            .pc_hit   (pc_hit),
            .addr_hit (addr_hit),
            .case_oh  (case_oh),
            .value_eq (value_eq),
            .any_en   (lvl_any[g]),
            .fire     (lvl_fire[g])
        );
    end

    logic two_lvl, complete, arm_set;

    assign two_lvl  = lvl_any[1];
    assign complete = !cfg_we && (two_lvl ? (lvl1_armed && lvl_fire[1]) : lvl_fire[0]);
    assign arm_set  = !cfg_we && two_lvl && !lvl1_armed && lvl_fire[0];

    always_ff @(posedge clk) begin
        if (rst || cfg_we)  lvl1_armed <= 1'b0;
        else if (complete)  lvl1_armed <= 1'b0;
        else if (arm_set)   lvl1_armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_done <= 1'b0;
            halt_req  <= 1'b0;
            dbg_irq   <= 1'b0;
        end else begin
            trig_done <= complete;
            halt_req  <= complete && (cfg_q.rsp == RSP_HALT);
            dbg_irq   <= complete && (cfg_q.rsp == RSP_IRQ);
        end
    end

    assert_halt_has_done_R11: assert property (@(posedge clk) disable iff (rst)
        halt_req |-> trig_done);
    assert_irq_has_done_R11: assert property (@(posedge clk) disable iff (rst)
        dbg_irq |-> trig_done);
    assert_rsvd_silent_R11: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_q.rsp == RSP_RSVD) |-> (!halt_req && !dbg_irq));
    assert_write_disarms_R10: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_we) |-> (!lvl1_armed && !trig_done));
    assert_done_disarms_R9: assert property (@(posedge clk) disable iff (rst)
        (trig_done && $past(two_lvl)) |-> !lvl1_armed);
    assert_arm_needs_acc_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(lvl1_armed) |-> $past(acc_valid));

endmodule

// File: tb/test_bp_trigger.sv
module test_bp_trigger;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_addr_lo = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_data = '0;
    logic [31:0] data_ref = '0;
    logic        pc_hit = 1'b0;
    logic        addr_hit = 1'b0;
    logic        trig_done, halt_req, dbg_irq, lvl1_armed;

    int checks = 0;
    int errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    bp_trigger i_bp_trigger (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr_lo(acc_addr_lo), .acc_size(acc_size),
        .acc_data(acc_data), .data_ref(data_ref), .pc_hit(pc_hit),
        .addr_hit(addr_hit), .trig_done(trig_done), .halt_req(halt_req),
        .dbg_irq(dbg_irq), .lvl1_armed(lvl1_armed)
    );

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed ^ (seed >> 15);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference evaluation of one level field from the requirement text
    function automatic bit model_lvl(input logic [12:0] f, input bit pc, input bit ah,
                                     input logic [1:0] a, input logic [1:0] sz,
                                     input logic [31:0] d, input logic [31:0] r);
        int idx = -1;
        bit eq = 0;
        logic [31:0] sh;
        bit dany, dc, pcc, ac, pt, at, dt;
        if (sz == 2'b10) begin idx = 0; eq = (d == r); end
        else if (sz == 2'b01) begin
            idx = 1 + int'(a[1]);
            sh  = d >> (16 * (1 - int'(a[1])));
            eq  = (sh[15:0] == r[15:0]);
        end else if (sz == 2'b00) begin
            idx = 3 + int'(a);
            sh  = d >> (8 * (3 - int'(a)));
            eq  = (sh[7:0] == r[7:0]);
        end
        dany = |f[12:6];
        dc   = (idx >= 0) && f[6 + idx] && (eq ^ f[5]);
        pcc  = pc ^ f[2];
        ac   = ah ^ f[4];
        if (!(f[1] || f[3] || dany)) return 0;
        pt = f[1] ? pcc : 1;
        at = f[3] ? ac : 1;
        dt = dany ? dc : 1;
        if (f[0]) return (f[1] && pcc) || ((f[3] || dany) && at && dt);
        return pt && at && dt;
    endfunction

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input bit pc, input bit ah, input logic [1:0] a,
                          input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; pc_hit = pc; addr_hit = ah;
        acc_addr_lo = a; acc_size = sz; acc_data = d;
        @(negedge clk);
    endtask

    task automatic idle_bus();
        acc_valid = 1'b0; pc_hit = 1'b0; addr_hit = 1'b0;
    endtask

    function automatic logic [31:0] near_data(input logic [31:0] r);
        logic [31:0] m = rnd();
        logic [31:0] k = '0;
        for (int i = 0; i < 4; i++) if (m[i] && m[i+4]) k[8*i +: 8] = m[15:8] | 8'h01;
        return r ^ k;
    endfunction

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [12:0] f1, f2;
        logic [1:0]  rsp, a, sz;
        logic [31:0] d;
        bit pc, ah, exp_done, exp_arm;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 done after reset", trig_done, 0);
        check("R1 halt after reset", halt_req, 0);
        check("R1 irq after reset", dbg_irq, 0);
        check("R1 armed after reset", lvl1_armed, 0);
        data_ref = 32'hA1B2C3D4;
        access(1, 1, 2'b00, 2'b10, 32'hA1B2C3D4);
        check("R1 cleared word never fires", trig_done, 0);
        idle_bus();

        // R8: idle level with only mode bit and unused bits set
        write_cfg(32'h6000_E001);
        access(1, 1, 2'b00, 2'b10, 32'hA1B2C3D4);
        check("R8 no enable no fire", trig_done, 0);
        idle_bus();

        // R5: each byte lane enabled alone, matching lane and non-matching lanes
        for (int ln = 0; ln < 4; ln++) begin
            write_cfg(32'(1) << (9 + ln));
            d = 32'h0;
            d[8*(3-ln) +: 8] = 8'hD4;
            for (int aa = 0; aa < 4; aa++) begin
                access(0, 0, 2'(aa), 2'b00, d);
                check("R5 byte lane select", trig_done, (aa == ln) ? 1 : 0);
                idle_bus();
            end
        end

        // R6: word lanes and long, plus size 11
        write_cfg(32'h0000_0180);
        access(0, 0, 2'b00, 2'b01, 32'hC3D4_0000);
        check("R6 upper word", trig_done, 1);
        access(0, 0, 2'b10, 2'b01, 32'h0000_C3D4);
        check("R6 lower word", trig_done, 1);
        access(0, 0, 2'b10, 2'b01, 32'hC3D4_0000);
        check("R6 lower word mismatch", trig_done, 0);
        write_cfg(32'h0000_1FC0);
        access(0, 0, 2'b00, 2'b11, 32'hA1B2C3D4);
        check("R6 size 11 no data match", trig_done, 0);
        idle_bus();

        // R12: no evaluation without acc_valid, pulse is one cycle
        write_cfg(32'h0000_0002);
        @(negedge clk);
        pc_hit = 1'b1;
        @(negedge clk);
        check("R12 ignored without valid", trig_done, 0);
        acc_valid = 1'b1;
        @(negedge clk);
        check("R12 one cycle latency", trig_done, 1);
        idle_bus();
        @(negedge clk);
        check("R12 pulse ends", trig_done, 0);

        // R10: write cycle with a matching access produces nothing
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 32'h4000_0002;
        acc_valid = 1'b1; pc_hit = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; idle_bus();
        check("R10 no completion in write cycle", trig_done, 0);

        // sweep single-level: R2 R3 R4 R5 R6 R7 R11
        for (int it = 0; it < 2500; it++) begin
            f1  = 13'(rnd());
            rsp = 2'(rnd());
            data_ref = rnd();
            write_cfg({rsp, 1'b0, 13'h0, 3'b0, f1});
            pc = rnd() % 2; ah = rnd() % 2;
            a = 2'(rnd()); sz = 2'(rnd());
            d = near_data(data_ref);
            exp_done = model_lvl(f1, pc, ah, a, sz, d, data_ref);
            access(pc, ah, a, sz, d);
            check("R3 R4 R7 single level", trig_done, exp_done);
            check("R11 halt", halt_req, exp_done && rsp == 2'b01);
            check("R11 irq", dbg_irq, exp_done && rsp == 2'b10);
            idle_bus();
        end

        // sweep two-level: R9 R2
        for (int it = 0; it < 600; it++) begin
            f1  = 13'(rnd());
            f2  = 13'(rnd()) | 13'h0002;
            rsp = 2'(rnd());
            data_ref = rnd();
            write_cfg({rsp, 1'b0, f2, 3'b0, f1});
            check("R10 disarmed after write", lvl1_armed, 0);
            exp_arm = 0;
            for (int st = 0; st < 3; st++) begin
                pc = rnd() % 2; ah = rnd() % 2;
                a = 2'(rnd()); sz = 2'(rnd());
                d = near_data(data_ref);
                if (exp_arm) begin
                    exp_done = model_lvl(f2, pc, ah, a, sz, d, data_ref);
                    exp_arm  = !exp_done;
                end else begin
                    exp_done = 0;
                    exp_arm  = model_lvl(f1, pc, ah, a, sz, d, data_ref);
                end
                access(pc, ah, a, sz, d);
                check("R9 two-level done", trig_done, exp_done);
                check("R9 armed state", lvl1_armed, exp_arm);
                check("R11 two-level halt", halt_req, exp_done && rsp == 2'b01);
                idle_bus();
            end
        end

        // R10: armed unit disarmed by a rewrite
        write_cfg(32'h0002_0002);
        access(1, 0, 2'b00, 2'b10, 0);
        check("R9 level one arms", lvl1_armed, 1);
        idle_bus();
        write_cfg(32'h0002_0002);
        check("R10 rewrite disarms", lvl1_armed, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule